// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block runs from a system clock and drives an external asynchronous 256K x 8 static RAM. The memory has two chip selects: one active low and one active high. Internal logic issues one access at a time. It raises a request together with a write flag, an 18-bit word address and, for a write, a data byte. When the access is finished the block returns a one-cycle completion pulse. For a read, the captured byte comes with that pulse.

Each memory timing minimum is given as a nanosecond parameter. A clock-period parameter turns it into a whole number of cycles, always rounding up. The memory write window is the time in which all three control levels are active at once. The block opens that window with write enable. It drives the shared data bus only after the memory output has had time to float. It holds the data for one cycle after write enable rises.

Between accesses both selects sit in the deselected state, so the memory stays in standby.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is applied and whenever the block is idle, the low-true select is 1, the high-true select is 0, write enable and output enable are both 1 (inactive), `ready_o` is 1 and `done_o` is 0.
- R2: Every phase length equals its nanosecond minimum divided by `CLK_NS`, rounded up. A zero minimum gives zero cycles. The write-enable-low window lasts max(write pulse, address-to-end, float time + data setup, write cycle - 1) cycles. Output enable is low for max(access time, output-enable time, read cycle - 1) cycles before the completion pulse. With the default parameters both windows are 5 cycles.
- R3: During a write, write enable is low only while both selects are active and output enable is high (1).
- R4: The controller drives the data bus only during a write, and never while output enable is low. It starts no earlier than the float-time count after write enable falls. It stops one cycle after write enable rises.
- R5: A read holds both selects active, output enable low and write enable high. The bus byte is captured on the clock edge that ends the access count. The byte appears on `rdata_o` in the cycle that `done_o` is 1. Output enable stays low in that cycle and returns high in the next one.
- R6: `done_o` is a single-cycle pulse at the end of each access. `ready_o` is 0 from the cycle after a request is accepted until the access ends. A request raised while `ready_o` is 0 is ignored and starts no access.
- R7: The byte given with a write is the byte later read back from the same address. A later write to that address replaces it.
- R8: The memory address stays constant for as long as the selects are active during one access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, taken when ready_o is 1 |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write byte |
| ready_o | output | 1 | Controller idle and able to accept |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read byte, valid with done_o |
| mem_cs_n_o | output | 1 | Low-true chip select |
| mem_cs_o | output | 1 | High-true chip select |
| mem_we_n_o | output | 1 | Low-true write enable |
| mem_oe_n_o | output | 1 | Low-true output enable |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_dq_io | inout | DATA_W | Shared data bus, released when not writing |

## Verification
A state register stuck or mis-decoded shows up at the pins in the first cycle after an access is accepted. Typical signs are a select that stays idle, write enable and output enable low together, or a bus driven against the memory's own output. An off-by-one in a phase counter changes the count of write-enable-low or output-enable-low cycles in that same access. It can also move the read capture one edge early, which shows up as a wrong byte paired with the completion pulse. A wrong buffer or latch surfaces only later, when a read-back of an address returns something other than the byte last written there.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WR    = 3'd1,
    ST_WHOLD = 3'd2,
    ST_RD    = 3'd3,
    ST_RDONE = 3'd4
  } sc_state_e;

  // nanoseconds to cycles, rounded up; nonzero minimum always >= 1 cycle
  function automatic int ns2cyc(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // length of the write-enable-low window in cycles
  function automatic int wr_cycles(input int wp, input int aw, input int whz,
                                   input int dw, input int wc);
    int r;
    r = imax(wp, aw);
    r = imax(r, whz + dw);
    r = imax(r, wc - 1);
    return imax(r, 1);
  endfunction

  // length of the output-enable-low access window before capture
  function automatic int rd_cycles(input int aa, input int oe, input int rc);
    int r;
    r = imax(aa, oe);
    r = imax(r, rc - 1);
    return imax(r, 1);
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WR_C  = 5,
  parameter int RD_C  = 5,
  parameter int WHZ_C = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [CW-1:0] cnt_i,
  output logic          accept_o,
  output logic          cnt_clr_o,
  output logic          sel_o,
  output logic          we_o,
  output logic          oe_o,
  output logic          dq_oe_o,
  output logic          cap_o,
  output logic          done_o,
  output logic          idle_o
);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_C - 1);
  localparam logic [CW-1:0] RD_LAST = CW'(RD_C - 1);
  localparam logic [CW-1:0] WHZ_CNT = CW'(WHZ_C);

  sc_state_e state_q, state_d;
  logic wr_last, rd_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign accept_o = idle_o && req_i;
  assign wr_last  = (state_q == ST_WR) && (cnt_i == WR_LAST);
  assign rd_last  = (state_q == ST_RD) && (cnt_i == RD_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = req_we_i ? ST_WR : ST_RD;
      ST_WR:    if (wr_last)  state_d = ST_WHOLD;
      ST_WHOLD: state_d = ST_IDLE;
      ST_RD:    if (rd_last)  state_d = ST_RDONE;
      ST_RDONE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr_o = (state_d != state_q) || idle_o;
  assign sel_o     = (state_q == ST_WR) || (state_q == ST_RD) || (state_q == ST_RDONE);
  assign we_o      = (state_q == ST_WR);
  assign oe_o      = (state_q == ST_RD) || (state_q == ST_RDONE);
  assign dq_oe_o   = ((state_q == ST_WR) && (cnt_i >= WHZ_CNT)) || (state_q == ST_WHOLD);
  assign cap_o     = rd_last;
  assign done_o    = (state_q == ST_WHOLD) || (state_q == ST_RDONE);
endmodule

// File: rtl/sram_dq_drv.sv
module sram_dq_drv #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              drive_i,
  input  logic              cap_i,
  inout  wire  [DATA_W-1:0] dq_io,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] wbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wbuf_q <= '0;
    else if (load_i) wbuf_q <= wdata_i;
  end

  assign dq_io = drive_i ? wbuf_q : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_o <= '0;
    else if (cap_i) rdata_o <= dq_io;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_WC_NS   = 45,
  parameter int T_WP_NS   = 35,
  parameter int T_AW_NS   = 45,
  parameter int T_DW_NS   = 25,
  parameter int T_WHZ_NS  = 15,
  parameter int T_RC_NS   = 45,
  parameter int T_AA_NS   = 45,
  parameter int T_OE_NS   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_cs_n_o,
  output logic              mem_cs_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  inout  wire  [DATA_W-1:0] mem_dq_io
);
  localparam int WHZ_C = ns2cyc(T_WHZ_NS, CLK_NS);
  localparam int WR_C  = wr_cycles(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS),
                                   WHZ_C, ns2cyc(T_DW_NS, CLK_NS),
                                   ns2cyc(T_WC_NS, CLK_NS));
  localparam int RD_C  = rd_cycles(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS),
                                   ns2cyc(T_RC_NS, CLK_NS));
  localparam int CW    = $clog2(imax(WR_C, RD_C) + 1);

  // named internal events
  logic          accept, cnt_clr, sel, we, oe, dq_oe, cap, idle;
  logic [CW-1:0] cnt;
  logic [ADDR_W-1:0] addr_q;

  sram_phase_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  sram_ctrl_fsm #(.WR_C(WR_C), .RD_C(RD_C), .WHZ_C(WHZ_C), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .req_we_i  (req_we_i),
    .cnt_i     (cnt),
    .accept_o  (accept),
    .cnt_clr_o (cnt_clr),
    .sel_o     (sel),
    .we_o      (we),
    .oe_o      (oe),
    .dq_oe_o   (dq_oe),
    .cap_o     (cap),
    .done_o    (done_o),
    .idle_o    (idle)
  );

  sram_dq_drv #(.DATA_W(DATA_W)) u_dq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .wdata_i (req_wdata_i),
    .drive_i (dq_oe),
    .cap_i   (cap),
    .dq_io   (mem_dq_io),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr_i;
  end

  assign ready_o    = idle;
  assign mem_addr_o = addr_q;
  assign mem_cs_n_o = ~sel;
  assign mem_cs_o   = sel;
  assign mem_we_n_o = ~we;
  assign mem_oe_n_o = ~oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int WHZ_C  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_o,
  input logic              done_o,
  input logic              mem_cs_n_o,
  input logic              mem_cs_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              dq_oe
);
  int unsigned we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           we_low_cnt <= 0;
    else if (!mem_we_n_o) we_low_cnt <= we_low_cnt + 1;
    else                  we_low_cnt <= 0;
  end

  // R1
  idle_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (mem_cs_n_o && !mem_cs_o && mem_we_n_o && mem_oe_n_o && !done_o));

  // R3
  we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> (!mem_cs_n_o && mem_cs_o && mem_oe_n_o));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mem_oe_n_o);

  // R4
  float_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !mem_we_n_o) |-> (we_low_cnt >= WHZ_C));

  // R4
  hold_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && mem_we_n_o) |-> $past(!mem_we_n_o));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n_o && done_o) |=> mem_oe_n_o);

  // R8
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .WHZ_C(WHZ_C)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .mem_cs_n_o (mem_cs_n_o),
  .mem_cs_o   (mem_cs_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_addr_o (mem_addr_o),
  .dq_oe      (dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int CLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready, done, cs_n, cs, we_n, oe_n;
  logic [DW-1:0] rdata;
  logic [AW-1:0] maddr;
  wire  [DW-1:0] dq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .mem_cs_n_o(cs_n), .mem_cs_o(cs), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_addr_o(maddr), .mem_dq_io(dq)
  );

  // behavioural memory
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic m_rd;
  logic [DW-1:0] m_out;
  assign m_rd  = !cs_n && cs && !oe_n && we_n;
  assign m_out = mem.exists(maddr) ? mem[maddr] : '0;
  assign dq    = m_rd ? m_out : {DW{1'bz}};

  logic was_wr = 1'b0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  always @(negedge clk) begin
    if (!cs_n && cs && !we_n) begin
      was_wr = 1'b1; last_a = maddr; last_d = dq;
    end else if (was_wr) begin
      mem[last_a] = last_d;
      was_wr = 1'b0;
    end
  end

  // bench's own cycle arithmetic: smallest c with c*CLK >= ns
  function automatic int cyc(input int ns);
    int c = 0;
    while (c * CLK < ns) c++;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction
  int exp_wr, exp_rd;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one access; returns counts and read byte
  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int we_cnt, output int oe_cnt, output bit addr_ok,
                        output logic [DW-1:0] rd);
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    we_cnt = 0; oe_cnt = 0; addr_ok = 1;
    while (!done) begin
      if (!we_n) we_cnt++;
      if (!oe_n) oe_cnt++;
      if (!cs_n && maddr != a) addr_ok = 0;
      @(negedge clk);
    end
    rd = rdata;
  endtask

  localparam int NV = 9;
  // {we, addr, data/expected}
  localparam logic [AW+DW:0] VEC [NV] = '{
    {1'b1, 18'h00000, 8'h5A},
    {1'b1, 18'h3FFFF, 8'hA5},
    {1'b1, 18'h12345, 8'h3C},
    {1'b0, 18'h00000, 8'h5A},
    {1'b0, 18'h3FFFF, 8'hA5},
    {1'b0, 18'h12345, 8'h3C},
    {1'b1, 18'h00000, 8'hC3},
    {1'b0, 18'h00000, 8'hC3},
    {1'b0, 18'h2AAAA, 8'h00}
  };

  initial begin
    int wc, oc;
    bit aok;
    logic [DW-1:0] rb;
    exp_wr = mx(mx(cyc(35), cyc(45)), mx(cyc(15) + cyc(25), cyc(45) - 1));
    exp_rd = mx(mx(cyc(45), cyc(25)), cyc(45) - 1);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n && !cs && we_n && oe_n, "R1", "selects/enables in reset",
          {cs_n, cs, we_n, oe_n}, 4'b1011);
    check(ready && !done, "R1", "ready/done in reset", {ready, done}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !cs && we_n && oe_n && ready, "R1", "idle after reset",
          {cs_n, cs, we_n, oe_n, ready}, 5'b10111);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][AW+DW], VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], wc, oc, aok, rb);
      check(aok, "R8", "address steady", 0, 0);
      if (VEC[i][AW+DW]) begin
        check(wc == exp_wr, "R2", "write-enable-low cycles", wc, exp_wr);
        check(oc == 0, "R3", "oe low during write", oc, 0);
      end else begin
        check(oc == exp_rd, "R2", "output-enable-low cycles", oc, exp_rd);
        check(wc == 0, "R5", "we low during read", wc, 0);
        check(rb == VEC[i][DW-1:0], "R7", "read-back byte", rb, VEC[i][DW-1:0]);
        check(!oe_n && !cs_n && cs, "R5", "oe held with done", oe_n, 0);
      end
      @(negedge clk);
      check(!done, "R6", "done single cycle", done, 0);
      check(ready && cs_n && oe_n && we_n, "R1", "idle after access",
            {ready, cs_n, oe_n, we_n}, 4'b1111);
    end

    // R6 request while busy is ignored
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 18'h00100; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 18'h00200; req_wdata = 8'h22;
    check(!ready, "R6", "ready low while busy", ready, 0);
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(ready && cs_n, "R6", "no extra access started", {ready, cs_n}, 2'b11);
    repeat (3) @(negedge clk);
    check(ready && cs_n && !cs, "R1", "standby kept", {ready, cs_n, cs}, 3'b110);
    access(1'b0, 18'h00200, 8'h00, wc, oc, aok, rb);
    check(rb == 8'h00, "R6", "busy request address untouched", rb, 8'h00);
    @(negedge clk);
    access(1'b0, 18'h00100, 8'h00, wc, oc, aok, rb);
    check(rb == 8'h11, "R7", "accepted write landed", rb, 8'h11);

    // R5 back-to-back reads on a single-cycle request
    @(negedge clk);
    access(1'b0, 18'h3FFFF, 8'h00, wc, oc, aok, rb);
    check(rb == 8'hA5, "R5", "second read of top address", rb, 8'hA5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule